// File: doc/BRIEF.md
# Synonym-Resolving Virtually Indexed Cache Tag Controller

This block holds the tag state and the lookup control for a two-level cache pair. The first level is 2-way set associative. It picks its set from virtual address bits and compares full physical page numbers. The second level is direct-mapped, physically indexed and inclusive of the first. Some of the first-level set bits lie above the page offset. Two virtual aliases of one physical block can therefore land in different first-level sets. To catch this, each second-level tag also records those virtual set bits, so an alias misses at the second level just like a conflict.

Any second-level replacement of a valid line reports the displaced block. It also searches the first-level set that the displaced line was allocated from, and invalidates the copy if one is still there. At most one cached copy of a physical block therefore survives. The set is rebuilt from the stored virtual bits and the page-offset part of the index. Each request is answered one cycle after acceptance. A miss leaves the block busy until the refill is signalled complete, and then the new line is installed in both levels.

Top module: `synonym_vipt_tags`

## Requirements
- R1: After reset, `ready` is high, no response or fill pulse is present, and every line in both levels is invalid. The first access to any block misses at both levels and displaces nothing.
- R2: A request accepted while `ready` is high gives `resp_valid` in the next cycle. `l1_hit` is set when a valid way of set `req_va[OFF_W +: PAGE_W-OFF_W+SYN_W]` holds the full `req_ppn`. On a first-level hit, `l2_hit`, `l2_evict` and `binv_valid` are low and `ready` stays high.
- R3: On a first-level miss, `l2_hit` is set when the second-level line at index `{req_ppn[L2_IDX_W-PAGE_W+OFF_W-1:0], req_va[PAGE_W-1:OFF_W]}` is valid, its physical tag equals the remaining upper PPN bits, and its stored synonym bits equal `req_va[PAGE_W +: SYN_W]`. A second-level hit displaces nothing.
- R4: A first-level miss whose second-level line is invalid reports `l2_hit` low and `l2_evict` low.
- R5: An access to a block held at the second level under different synonym bits misses there. It reports `l2_evict` for that block and back-invalidates the aliased first-level copy.
- R6: A second-level miss on a valid line reports `l2_evict` with `evict_blk` = {displaced PPN, page-offset index bits}. If the displaced block is still in the first level, `binv_valid` is set and `binv_set` = {stored synonym bits, page-offset index bits}, with `binv_way` giving the way holding it.
- R7: After a back-invalidation, an access with the old virtual alias misses the first level.
- R8: After a miss response, `ready` is low until the fill completes. Requests presented while busy are ignored and produce no response.
- R9: The cycle after `fill_done` is sampled high while busy, `fill_valid` pulses with `fill_set` equal to the missing set, and `ready` returns high.
- R10: A fill uses way 0 if it is invalid, otherwise way 1 if it is invalid, otherwise the way named by the set's replacement bit. Hits and fills point that bit at the other way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_va | input | VA_W | Virtual address of the request |
| req_ppn | input | PPN_W | Translated physical page number |
| fill_done | input | 1 | Refill data has arrived for the outstanding miss |
| ready | output | 1 | Idle and accepting a request |
| resp_valid | output | 1 | Lookup result pulse |
| l1_hit | output | 1 | First-level hit |
| l2_hit | output | 1 | Second-level hit on a first-level miss |
| l2_evict | output | 1 | A valid second-level line is being replaced |
| evict_blk | output | PPN_W+PAGE_W-OFF_W | Physical block number of the displaced line |
| binv_valid | output | 1 | First-level copy invalidated for inclusion |
| binv_set | output | PAGE_W-OFF_W+SYN_W | Set of the invalidated copy |
| binv_way | output | 1 | Way of the invalidated copy |
| fill_valid | output | 1 | Line installed pulse |
| fill_set | output | PAGE_W-OFF_W+SYN_W | Set that was filled |
| fill_way | output | 1 | Way that was filled |

## Verification
A wrong tag, valid or synonym bit shows up at the ports only when a later request touches the affected set or second-level index. It appears as a wrong hit flag or a missing or extra eviction one cycle after that request. A wrong replacement bit shows as a wrong `fill_way` on the next fill into that set. The bench therefore sweeps many aliases and conflicting pages over a 16-set, 16-line configuration, so that every stale state is revisited soon after it is created.

// File: rtl/svc_pkg.sv
`timescale 1ns/1ps
package svc_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } ctl_state_e;

    // invalid way first (lowest), otherwise the way the replacement bit names
    function automatic logic pick_victim(input logic v0, input logic v1, input logic lru);
        if (!v0)      return 1'b0;
        else if (!v1) return 1'b1;
        else          return lru;
    endfunction

endpackage

// File: rtl/svc_l1_tags.sv
`timescale 1ns/1ps
module svc_l1_tags
    import svc_pkg::*;
#(
    parameter int SET_W = 10,
    parameter int TAG_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic             lk_way,
    input  logic [SET_W-1:0] bi_set,
    input  logic [TAG_W-1:0] bi_tag,
    output logic             bi_hit,
    output logic             bi_way,
    input  logic             inv_en,
    input  logic [SET_W-1:0] inv_set,
    input  logic             inv_way,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic             touch_way,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [TAG_W-1:0] wr_tag,
    output logic             wr_way
);
    localparam int SETS = 1 << SET_W;
    localparam int WAYS = 2;

    logic [WAYS-1:0]  vld_q [SETS];
    logic [WAYS-1:0]  vld_d [SETS];
    logic             lru_q [SETS];
    logic             lru_d [SETS];
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [TAG_W-1:0] tag_d [SETS][WAYS];

    logic [WAYS-1:0] lk_match;
    logic [WAYS-1:0] bi_match;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign lk_match[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
        assign bi_match[w] = vld_q[bi_set][w] && (tag_q[bi_set][w] == bi_tag);
    end

    assign lk_hit = |lk_match;
    assign lk_way = lk_match[1];
    assign bi_hit = |bi_match;
    assign bi_way = bi_match[1];
    assign wr_way = pick_victim(vld_q[wr_set][0], vld_q[wr_set][1], lru_q[wr_set]);

    always_comb begin
        vld_d = vld_q;
        lru_d = lru_q;
        tag_d = tag_q;
        if (inv_en) vld_d[inv_set][inv_way] = 1'b0;
        if (touch_en) lru_d[touch_set] = ~touch_way;
        if (wr_en) begin
            vld_d[wr_set][wr_way] = 1'b1;
            tag_d[wr_set][wr_way] = wr_tag;
            lru_d[wr_set]         = ~wr_way;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) begin
                vld_q[i] <= '0;
                lru_q[i] <= 1'b0;
            end
        end else begin
            vld_q <= vld_d;
            lru_q <= lru_d;
        end
    end

    always_ff @(posedge clk) begin
        tag_q <= tag_d;
    end

endmodule

// File: rtl/svc_l2_tags.sv
`timescale 1ns/1ps
module svc_l2_tags #(
    parameter int IDX_W = 10,
    parameter int TAG_W = 18,
    parameter int SYN_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_vld,
    output logic [TAG_W-1:0] rd_tag,
    output logic [SYN_W-1:0] rd_syn,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [SYN_W-1:0] wr_syn
);
    localparam int LINES = 1 << IDX_W;

    typedef struct packed {
        logic             vld;
        logic [SYN_W-1:0] syn;
        logic [TAG_W-1:0] tag;
    } l2_ent_t;

    l2_ent_t ent_q [LINES];
    l2_ent_t ent_d [LINES];

    assign rd_vld = ent_q[rd_idx].vld;
    assign rd_tag = ent_q[rd_idx].tag;
    assign rd_syn = ent_q[rd_idx].syn;

    always_comb begin
        ent_d = ent_q;
        if (wr_en) begin
            ent_d[wr_idx].vld = 1'b1;
            ent_d[wr_idx].syn = wr_syn;
            ent_d[wr_idx].tag = wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) ent_q[i] <= '0;
        end else begin
            ent_q <= ent_d;
        end
    end

endmodule

// File: rtl/synonym_vipt_tags.sv
`timescale 1ns/1ps
module synonym_vipt_tags
    import svc_pkg::*;
#(
    parameter int VA_W     = 32,
    parameter int PPN_W    = 20,
    parameter int OFF_W    = 4,
    parameter int PAGE_W   = 12,
    parameter int SYN_W    = 2,
    parameter int L2_IDX_W = 10
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                req_valid,
    input  logic [VA_W-1:0]                     req_va,
    input  logic [PPN_W-1:0]                    req_ppn,
    input  logic                                fill_done,
    output logic                                ready,
    output logic                                resp_valid,
    output logic                                l1_hit,
    output logic                                l2_hit,
    output logic                                l2_evict,
    output logic [PPN_W+PAGE_W-OFF_W-1:0]       evict_blk,
    output logic                                binv_valid,
    output logic [PAGE_W-OFF_W+SYN_W-1:0]       binv_set,
    output logic                                binv_way,
    output logic                                fill_valid,
    output logic [PAGE_W-OFF_W+SYN_W-1:0]       fill_set,
    output logic                                fill_way
);
    localparam int PG_IDX_W = PAGE_W - OFF_W;
    localparam int L1_SET_W = PG_IDX_W + SYN_W;
    localparam int L2_HI_W  = L2_IDX_W - PG_IDX_W;
    localparam int L2_TAG_W = PPN_W - L2_HI_W;
    localparam int BLK_W    = PPN_W + PG_IDX_W;

    typedef struct packed {
        ctl_state_e            state;
        logic [L1_SET_W-1:0]   h_set;
        logic [PPN_W-1:0]      h_ppn;
        logic [L2_IDX_W-1:0]   h_l2i;
        logic [SYN_W-1:0]      h_syn;
        logic                  h_l2wr;
        logic                  resp_valid;
        logic                  l1_hit;
        logic                  l2_hit;
        logic                  l2_evict;
        logic [BLK_W-1:0]      evict_blk;
        logic                  binv_valid;
        logic [L1_SET_W-1:0]   binv_set;
        logic                  binv_way;
        logic                  fill_valid;
        logic [L1_SET_W-1:0]   fill_set;
        logic                  fill_way;
    } ctl_t;

    ctl_t q, d;

    // address slicing
    logic [L1_SET_W-1:0] req_set;
    logic [PG_IDX_W-1:0] req_pgi;
    logic [SYN_W-1:0]    req_syn;
    logic [L2_IDX_W-1:0] req_l2i;
    logic [L2_TAG_W-1:0] req_l2t;

    assign req_set = req_va[OFF_W +: L1_SET_W];
    assign req_pgi = req_va[OFF_W +: PG_IDX_W];
    assign req_syn = req_va[PAGE_W +: SYN_W];
    assign req_l2i = {req_ppn[L2_HI_W-1:0], req_pgi};
    assign req_l2t = req_ppn[PPN_W-1:L2_HI_W];

    if (VA_W > PAGE_W + SYN_W) begin : g_va_hi
        logic unused_va_hi;
        assign unused_va_hi = ^{req_va[VA_W-1:PAGE_W+SYN_W], req_va[OFF_W-1:0]};
    end else begin : g_va_lo
        logic unused_va_lo;
        assign unused_va_lo = ^req_va[OFF_W-1:0];
    end

    // level-two tag array
    logic                l2_vld;
    logic [L2_TAG_W-1:0] l2_tag;
    logic [SYN_W-1:0]    l2_syn;
    logic                l2_wr_en;

    svc_l2_tags #(
        .IDX_W (L2_IDX_W),
        .TAG_W (L2_TAG_W),
        .SYN_W (SYN_W)
    ) u_l2 (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (req_l2i),
        .rd_vld (l2_vld),
        .rd_tag (l2_tag),
        .rd_syn (l2_syn),
        .wr_en  (l2_wr_en),
        .wr_idx (q.h_l2i),
        .wr_tag (q.h_ppn[PPN_W-1:L2_HI_W]),
        .wr_syn (q.h_syn)
    );

    // the displaced line: its page number and the L1 set it was allocated from
    logic [PPN_W-1:0]    old_ppn;
    logic [L1_SET_W-1:0] old_set;
    logic                l2_match;

    assign old_ppn  = {l2_tag, req_ppn[L2_HI_W-1:0]};
    assign old_set  = {l2_syn, req_pgi};
    assign l2_match = l2_vld && (l2_tag == req_l2t) && (l2_syn == req_syn);

    // level-one tag array
    logic accept, lk_hit, lk_way, bi_hit, bi_way, do_evict, inv_en, touch_en;
    logic l1_wr_en, l1_wr_way;

    assign accept   = (q.state == ST_IDLE) && req_valid;
    assign do_evict = accept && !lk_hit && !l2_match && l2_vld;
    assign inv_en   = do_evict && bi_hit;
    assign touch_en = accept && lk_hit;
    assign l1_wr_en = (q.state == ST_FILL) && fill_done;
    assign l2_wr_en = l1_wr_en && q.h_l2wr;

    svc_l1_tags #(
        .SET_W (L1_SET_W),
        .TAG_W (PPN_W)
    ) u_l1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_set    (req_set),
        .lk_tag    (req_ppn),
        .lk_hit    (lk_hit),
        .lk_way    (lk_way),
        .bi_set    (old_set),
        .bi_tag    (old_ppn),
        .bi_hit    (bi_hit),
        .bi_way    (bi_way),
        .inv_en    (inv_en),
        .inv_set   (old_set),
        .inv_way   (bi_way),
        .touch_en  (touch_en),
        .touch_set (req_set),
        .touch_way (lk_way),
        .wr_en     (l1_wr_en),
        .wr_set    (q.h_set),
        .wr_tag    (q.h_ppn),
        .wr_way    (l1_wr_way)
    );

    always_comb begin
        d            = q;
        d.resp_valid = 1'b0;
        d.l1_hit     = 1'b0;
        d.l2_hit     = 1'b0;
        d.l2_evict   = 1'b0;
        d.binv_valid = 1'b0;
        d.fill_valid = 1'b0;
        if (accept) begin
            d.resp_valid = 1'b1;
            d.l1_hit     = lk_hit;
            if (!lk_hit) begin
                d.l2_hit     = l2_match;
                d.l2_evict   = do_evict;
                d.evict_blk  = {old_ppn, req_pgi};
                d.binv_valid = inv_en;
                d.binv_set   = old_set;
                d.binv_way   = bi_way;
                d.state      = ST_FILL;
                d.h_set      = req_set;
                d.h_ppn      = req_ppn;
                d.h_l2i      = req_l2i;
                d.h_syn      = req_syn;
                d.h_l2wr     = !l2_match;
            end
        end
        if (l1_wr_en) begin
            d.state      = ST_IDLE;
            d.fill_valid = 1'b1;
            d.fill_set   = q.h_set;
            d.fill_way   = l1_wr_way;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ready      = (q.state == ST_IDLE);
    assign resp_valid = q.resp_valid;
    assign l1_hit     = q.l1_hit;
    assign l2_hit     = q.l2_hit;
    assign l2_evict   = q.l2_evict;
    assign evict_blk  = q.evict_blk;
    assign binv_valid = q.binv_valid;
    assign binv_set   = q.binv_set;
    assign binv_way   = q.binv_way;
    assign fill_valid = q.fill_valid;
    assign fill_set   = q.fill_set;
    assign fill_way   = q.fill_way;

endmodule

// File: rtl/svc_tags_chk.sv
`timescale 1ns/1ps
module svc_tags_chk #(
    parameter int PGI_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ready,
    input logic             resp_valid,
    input logic             l1_hit,
    input logic             l2_hit,
    input logic             l2_evict,
    input logic [PGI_W-1:0] evict_pgi,
    input logic             binv_valid,
    input logic [PGI_W-1:0] binv_pgi,
    input logic             fill_valid,
    input logic             fill_done
);
    // R1
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({resp_valid, fill_valid}));

    // R2
    l1_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && l1_hit) |-> (!l2_hit && !l2_evict && !binv_valid && ready));

    // R3
    l2_hit_no_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l2_hit |-> (resp_valid && !l1_hit && !l2_evict && !binv_valid));

    // R5
    binv_needs_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        binv_valid |-> l2_evict);

    // R6
    binv_page_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        binv_valid |-> (binv_pgi == evict_pgi));

    // R8
    miss_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !l1_hit) |-> !ready);

    // R8
    ready_only_by_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> fill_valid);

    // R9
    fill_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> ($past(fill_done) && ready));

endmodule

bind synonym_vipt_tags svc_tags_chk #(
    .PGI_W (PG_IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready      (ready),
    .resp_valid (resp_valid),
    .l1_hit     (l1_hit),
    .l2_hit     (l2_hit),
    .l2_evict   (l2_evict),
    .evict_pgi  (evict_blk[PG_IDX_W-1:0]),
    .binv_valid (binv_valid),
    .binv_pgi   (binv_set[PG_IDX_W-1:0]),
    .fill_valid (fill_valid),
    .fill_done  (fill_done)
);

// File: tb/test_synonym_vipt_tags.sv
`timescale 1ns/1ps
module test_synonym_vipt_tags;

    // small configuration: 16 L1 sets x 2 ways, 16 L2 lines
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [7:0] req_va = '0;
    logic [3:0] req_ppn = '0;
    logic       fill_done = 1'b0;
    logic       ready, resp_valid, l1_hit, l2_hit, l2_evict;
    logic [5:0] evict_blk;
    logic       binv_valid, binv_way, fill_valid, fill_way;
    logic [3:0] binv_set, fill_set;

    int compared = 0;
    int mismatched = 0;

    // reference state
    logic       m1v  [16][2];
    logic [3:0] m1t  [16][2];
    logic       mlru [16];
    logic       m2v  [16];
    logic [1:0] m2t  [16];
    logic [1:0] m2s  [16];

    always #2.5 clk = ~clk;

    synonym_vipt_tags #(
        .VA_W(8), .PPN_W(4), .OFF_W(4), .PAGE_W(6), .SYN_W(2), .L2_IDX_W(4)
    ) i_synonym_vipt_tags (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .req_ppn(req_ppn), .fill_done(fill_done), .ready(ready),
        .resp_valid(resp_valid), .l1_hit(l1_hit), .l2_hit(l2_hit),
        .l2_evict(l2_evict), .evict_blk(evict_blk), .binv_valid(binv_valid),
        .binv_set(binv_set), .binv_way(binv_way), .fill_valid(fill_valid),
        .fill_set(fill_set), .fill_way(fill_way)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic access(input logic [7:0] va, input logic [3:0] ppn, input int lat,
                          input string tag_in);
        logic [3:0] set, l2i, oset, optn;
        logic [1:0] syn, pg, l2t;
        logic       e_l1, e_hw, e_l2, e_ev, e_bi, e_bw, e_fw;
        logic [5:0] e_blk;
        string      tag;
        set  = va[7:4];
        syn  = va[7:6];
        pg   = va[5:4];
        l2i  = {ppn[1:0], pg};
        l2t  = ppn[3:2];
        e_hw = m1v[set][1] && (m1t[set][1] == ppn);
        e_l1 = (m1v[set][0] && (m1t[set][0] == ppn)) || e_hw;
        e_l2 = !e_l1 && m2v[l2i] && (m2t[l2i] == l2t) && (m2s[l2i] == syn);
        e_ev = !e_l1 && !e_l2 && m2v[l2i];
        e_blk = {m2t[l2i], l2i};
        oset = {m2s[l2i], pg};
        optn = {m2t[l2i], ppn[1:0]};
        e_bi = 1'b0;
        e_bw = 1'b0;
        if (e_ev) begin
            for (int w = 0; w < 2; w++) begin
                if (m1v[oset][w] && (m1t[oset][w] == optn)) begin
                    e_bi = 1'b1;
                    e_bw = w[0];
                end
            end
        end
        if (tag_in != "")                tag = tag_in;
        else if (e_l1)                   tag = "R2";
        else if (e_l2)                   tag = "R3";
        else if (!m2v[l2i])              tag = "R4";
        else if (m2t[l2i] == l2t)        tag = "R5";
        else                             tag = "R6";

        @(negedge clk);
        req_valid = 1'b1;
        req_va    = va;
        req_ppn   = ppn;
        @(negedge clk);
        req_valid = 1'b0;
        chk(tag, "resp_valid", int'(resp_valid), 1);
        chk(tag, "l1_hit", int'(l1_hit), int'(e_l1));
        chk(tag, "l2_hit", int'(l2_hit), int'(e_l2));
        chk(tag, "l2_evict", int'(l2_evict), int'(e_ev));
        chk(tag, "binv_valid", int'(binv_valid), int'(e_bi));
        if (e_ev) chk(tag, "evict_blk", int'(evict_blk), int'(e_blk));
        if (e_bi) begin
            chk(tag, "binv_set", int'(binv_set), int'(oset));
            chk(tag, "binv_way", int'(binv_way), int'(e_bw));
        end

        if (e_l1) begin
            chk("R2", "ready after hit", int'(ready), 1);
            mlru[set] = ~e_hw;
        end else begin
            if (e_bi) m1v[oset][e_bw] = 1'b0;
            for (int i = 0; i < lat; i++) begin
                req_valid = 1'b1;
                req_va    = ~va;
                req_ppn   = ~ppn;
                @(negedge clk);
                chk("R8", "ready while busy", int'(ready), 0);
                chk("R8", "resp while busy", int'(resp_valid), 0);
            end
            req_valid = 1'b0;
            fill_done = 1'b1;
            @(negedge clk);
            fill_done = 1'b0;
            e_fw = !m1v[set][0] ? 1'b0 : (!m1v[set][1] ? 1'b1 : mlru[set]);
            chk("R9", "fill_valid", int'(fill_valid), 1);
            chk("R9", "fill_set", int'(fill_set), int'(set));
            chk("R9", "ready after fill", int'(ready), 1);
            chk("R10", "fill_way", int'(fill_way), int'(e_fw));
            m1v[set][e_fw] = 1'b1;
            m1t[set][e_fw] = ppn;
            mlru[set]      = ~e_fw;
            if (!e_l2) begin
                m2v[l2i] = 1'b1;
                m2t[l2i] = l2t;
                m2s[l2i] = syn;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int unsigned rs;
        for (int s = 0; s < 16; s++) begin
            m1v[s][0] = 1'b0; m1v[s][1] = 1'b0;
            m1t[s][0] = '0;   m1t[s][1] = '0;
            mlru[s] = 1'b0;
            m2v[s] = 1'b0; m2t[s] = '0; m2s[s] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle and quiet after reset
        chk("R1", "ready", int'(ready), 1);
        chk("R1", "resp_valid", int'(resp_valid), 0);
        chk("R1", "fill_valid", int'(fill_valid), 0);

        access(8'h00, 4'd0, 1, "R1");   // cold: miss both levels, nothing displaced
        access(8'h00, 4'd0, 0, "");     // R2 hit
        access(8'h0F, 4'd0, 0, "R2");   // offset bits do not matter
        access(8'h00, 4'd4, 2, "");     // R6 conflict at L2 index 0
        access(8'h40, 4'd4, 1, "");     // R5 synonym of the same block
        access(8'h00, 4'd4, 0, "R7");   // old alias was invalidated
        access(8'h80, 4'd1, 1, "");
        access(8'h80, 4'd3, 1, "");
        access(8'h80, 4'd1, 0, "");     // hit makes way holding ppn 3 the LRU one
        access(8'h80, 4'd2, 1, "R10");  // replaces LRU way
        access(8'h80, 4'd3, 1, "");     // R3: still at L2 with same synonym bits

        rs = 32'h1234_5678;
        for (int n = 0; n < 1500; n++) begin
            rs = rs * 32'd1664525 + 32'd1013904223;
            access(rs[23:16], rs[27:24], int'(rs[29:28]), "");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule